// File: doc/BRIEF.md
# Truncated-Sequence Synchronous Counter

This block is a synchronous binary counter that runs through fewer states than its full binary range allows. It is built from one or more fixed-width counting slices. The slices are chained so that a slice advances only while every slice below it holds all ones. A terminal event ends each cycle of the count. A compile-time mode parameter selects how that event shortens the sequence.

In reload mode, the all-ones state of the chain feeds back into the parallel load, and the next edge jumps to a preset value. In detect-clear mode, a decoder watches for one chosen count and clears the counter. The clear can act immediately, which makes the decoded state invisible, or it can act on the next clock edge, which lets the decoded state last for one full cycle. The two forms differ in modulus by one. Free-run mode uses the whole binary range.

A load request places the preset into the counter at the next edge to start a sequence. A one-cycle wrap flag marks the last state of every cycle, so a following stage or divider can use it as a single-clock pulse.

Top module: `trunc_counter`

## Requirements
- R1: While rst_n is low, count is 0 and wrap is 0, without waiting for a clock edge.
- R2: When neither wrap nor load_req is high, each rising edge increments count by exactly one.
- R3: When load_req is high and wrap is low, the next edge sets count to PRESET, whatever value count had before.
- R4: Reload mode with one 4-bit slice and PRESET 9: wrap is high at count 15, and the next edge loads 9. The cycle is 9..15, which is 7 states.
- R5: Upper slices advance only on an edge where all lower bits are ones. With three 4-bit slices, 16 edges after reset give count 16, and 256 edges give 256.
- R6: Reload mode with three 4-bit slices and PRESET 0x800 has a 2048-state cycle that starts at 0x800. Free-run mode with the same chain has a 4096-state cycle, with wrap at 0xFFF.
- R7: Immediate-clear mode with DETECT 9: count never shows 9, wrap is high at 8, and the next state is 0. The cycle has 9 states.
- R8: Next-edge-clear mode with DETECT 9: count holds 9 for one cycle, with wrap high, and then goes to 0. The cycle has 10 states.
- R9: wrap is high for exactly one clock per cycle, in the last state of the cycle. After it, the next state is the cycle's start value: PRESET in reload mode, 0 otherwise.
- R10: In either clear mode, a load_req that coincides with wrap is overridden, and the next state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_req | input | 1 | Load PRESET at the next edge |
| count | output | STAGE_W*STAGES | Current count |
| wrap | output | 1 | High in the last state of each cycle |

## Verification
A wrong terminal decode or a wrong load priority shows up as a cycle length that differs from the expected modulus. It appears within one period, which is at most 4096 clocks. A broken carry between slices shows up as a wrong upper count within 16 clocks of reset. A wrap pulse that lasts more than one cycle, or a wrong restart value, is visible on the first edge after wrap.

// File: rtl/tc_pkg.sv
package tc_pkg;
   typedef enum logic [1:0] {
      TC_RELOAD    = 2'd0,
      TC_FREE      = 2'd1,
      TC_CLR_ASYNC = 2'd2,
      TC_CLR_SYNC  = 2'd3
   } tc_mode_e;
endpackage

// File: rtl/tc_stage.sv
module tc_stage #(
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic          en,
   input  logic [SW-1:0] d,
   output logic [SW-1:0] q,
   output logic          tc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (load) q <= d;
      else if (en)   q <= q + SW'(1);
   end

   assign tc = en & (&q);

   // R5: a slice without enable, clear or load holds its value
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr && !load) |=> $stable(q));
endmodule

// File: rtl/tc_decode.sv
module tc_decode
   import tc_pkg::*;
#(
   parameter int       W      = 4,
   parameter tc_mode_e MODE   = TC_RELOAD,
   parameter int       DETECT = 9
) (
   input  logic [W-1:0] count,
   input  logic         top_tc,
   output logic         reload,
   output logic         clear,
   output logic         wrap
);
   localparam logic [W-1:0] HIT_V  = W'(DETECT);
   localparam logic [W-1:0] LAST_V = W'(DETECT - 1);

   generate
      if (MODE == TC_RELOAD) begin : g_reload
         assign reload = top_tc;
         assign clear  = 1'b0;
         assign wrap   = top_tc;
      end else if (MODE == TC_FREE) begin : g_free
         assign reload = 1'b0;
         assign clear  = 1'b0;
         assign wrap   = top_tc;
      end else if (MODE == TC_CLR_ASYNC) begin : g_async
         // the decoded state is cleared as soon as it would appear,
         // so the clear is folded into the edge that would enter it
         assign reload = 1'b0;
         assign clear  = (count == LAST_V);
         assign wrap   = clear;
      end else begin : g_sync
         assign reload = 1'b0;
         assign clear  = (count == HIT_V);
         assign wrap   = clear;
      end
   endgenerate
endmodule

// File: rtl/trunc_counter.sv
module trunc_counter
   import tc_pkg::*;
#(
   parameter int       STAGE_W = 4,
   parameter int       STAGES  = 1,
   parameter tc_mode_e MODE    = TC_RELOAD,
   parameter int       PRESET  = 9,
   parameter int       DETECT  = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_req,
   output logic [STAGE_W*STAGES-1:0] count,
   output logic                      wrap
);
   localparam int           W       = STAGE_W * STAGES;
   localparam logic [W-1:0] PRE_V   = W'(PRESET);
   localparam logic [W-1:0] START_V = (MODE == TC_RELOAD) ? PRE_V : '0;

   generate
      if (STAGE_W < 1 || STAGES < 1) begin : g_bad_shape
         $error("trunc_counter: STAGE_W and STAGES must be at least 1");
      end
      if (PRESET < 0 || PRESET >= (1 << W)) begin : g_bad_preset
         $error("trunc_counter: PRESET out of range");
      end
      if (MODE == TC_CLR_ASYNC || MODE == TC_CLR_SYNC) begin : g_chk_det
         if (DETECT < 2 || DETECT >= (1 << W)) begin : g_bad_detect
            $error("trunc_counter: DETECT out of range");
         end
      end
   endgenerate

   logic [STAGES:0] carry;
   logic            reload, clear, load_all;

   assign carry[0] = 1'b1;
   assign load_all = load_req | reload;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_slice
         tc_stage #(.SW(STAGE_W)) u_slice (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clear),
            .load (load_all),
            .en   (carry[i]),
            .d    (PRE_V[i*STAGE_W +: STAGE_W]),
            .q    (count[i*STAGE_W +: STAGE_W]),
            .tc   (carry[i+1])
         );
      end
   endgenerate

   tc_decode #(.W(W), .MODE(MODE), .DETECT(DETECT)) u_dec (
      .count (count),
      .top_tc(carry[STAGES]),
      .reload(reload),
      .clear (clear),
      .wrap  (wrap)
   );

   a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap && !load_req) |=> count == $past(count) + W'(1));

   a_r3_load_preset: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !wrap) |=> count == PRE_V);

   // R9 and R10: the state after wrap is always the cycle start
   a_r9_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == START_V && !wrap));

   generate
      if (MODE == TC_CLR_ASYNC) begin : g_a_async
         a_r7_hidden_state: assert property (@(posedge clk) disable iff (!rst_n)
            count != W'(DETECT));
      end
   endgenerate
endmodule

// File: tb/trunc_counter_test.sv
module trunc_counter_test;
   import tc_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_a = 1'b0, ld_12r = 1'b0, ld_12f = 1'b0, ld_as = 1'b0, ld_ss = 1'b0;
   logic [3:0]  c_a, c_as, c_ss;
   logic [11:0] c_12r, c_12f;
   logic        w_a, w_12r, w_12f, w_as, w_ss;
   logic [11:0] cv [5];
   logic [4:0]  wv;
   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   trunc_counter #(.STAGE_W(4), .STAGES(1), .MODE(TC_RELOAD), .PRESET(9)) uut (
      .clk(clk), .rst_n(rst_n), .load_req(ld_a), .count(c_a), .wrap(w_a));
   trunc_counter #(.STAGE_W(4), .STAGES(3), .MODE(TC_RELOAD), .PRESET(12'h800)) uut_12r (
      .clk(clk), .rst_n(rst_n), .load_req(ld_12r), .count(c_12r), .wrap(w_12r));
   trunc_counter #(.STAGE_W(4), .STAGES(3), .MODE(TC_FREE), .PRESET(0)) uut_12f (
      .clk(clk), .rst_n(rst_n), .load_req(ld_12f), .count(c_12f), .wrap(w_12f));
   trunc_counter #(.STAGE_W(4), .STAGES(1), .MODE(TC_CLR_ASYNC), .PRESET(5), .DETECT(9)) uut_as (
      .clk(clk), .rst_n(rst_n), .load_req(ld_as), .count(c_as), .wrap(w_as));
   trunc_counter #(.STAGE_W(4), .STAGES(1), .MODE(TC_CLR_SYNC), .PRESET(5), .DETECT(9)) uut_ss (
      .clk(clk), .rst_n(rst_n), .load_req(ld_ss), .count(c_ss), .wrap(w_ss));

   assign cv[0] = {8'h00, c_a};
   assign cv[1] = c_12r;
   assign cv[2] = c_12f;
   assign cv[3] = {8'h00, c_as};
   assign cv[4] = {8'h00, c_ss};
   assign wv    = {w_ss, w_as, w_12f, w_12r, w_a};

   // {load_req, expected count, expected wrap} after each edge, 4-bit reload unit
   localparam logic [5:0] VECS [18] = '{
      6'b1_1001_0, 6'b0_1010_0, 6'b0_1011_0, 6'b0_1100_0, 6'b0_1101_0, 6'b0_1110_0,
      6'b0_1111_1, 6'b0_1001_0, 6'b0_1010_0, 6'b1_1001_0, 6'b0_1010_0, 6'b0_1011_0,
      6'b0_1100_0, 6'b0_1101_0, 6'b0_1110_0, 6'b0_1111_1, 6'b1_1001_0, 6'b0_1010_0};

   task automatic check(string req, logic [11:0] act, logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic measure(int idx, int exp_len, logic [11:0] exp_start,
                          logic [11:0] probe, logic exp_seen, string req);
      int n = 0;
      int len = 1;
      logic seen = 1'b0;
      while (!wv[idx] && n < 6000) begin
         @(posedge clk); #1; n++;
      end
      @(posedge clk); #1;
      check({req, " start"}, cv[idx], exp_start);
      check("R9 wrap single cycle", {11'd0, wv[idx]}, 12'd0);
      while (len < 6000) begin
         if (cv[idx] == probe) seen = 1'b1;
         if (wv[idx]) break;
         @(posedge clk); #1; len++;
      end
      check({req, " cycle length"}, 12'(len), 12'(exp_len));
      check({req, " probe state"}, {11'd0, seen}, {11'd0, exp_seen});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk); #1;
      check("R1 reset count", c_12r, 12'd0);
      check("R1 reset wrap", {7'd0, wv}, 12'd0);
      rst_n = 1'b1;

      // R4 / R3 / R2: vector walk on the 4-bit reload unit
      foreach (VECS[i]) begin
         ld_a = VECS[i][5];
         @(posedge clk); #1;
         check("R4 vector count", {8'd0, c_a}, {8'd0, VECS[i][4:1]});
         check("R9 vector wrap", {11'd0, w_a}, {11'd0, VECS[i][0]});
      end
      ld_a = 1'b0;

      measure(0, 7,    12'd9,   12'd8,   1'b0, "R4");
      measure(1, 2048, 12'h800, 12'h7FF, 1'b0, "R6 reload");
      measure(2, 4096, 12'h000, 12'hFFF, 1'b1, "R6 free");
      measure(3, 9,    12'd0,   12'd9,   1'b0, "R7");
      measure(4, 10,   12'd0,   12'd9,   1'b1, "R8");

      // R10: load coinciding with wrap is overridden in both clear modes
      while (!w_ss) begin @(posedge clk); #1; end
      check("R8 held at detect", {8'd0, c_ss}, 12'd9);
      ld_ss = 1'b1;
      @(posedge clk); #1;
      check("R10 sync clear beats load", {8'd0, c_ss}, 12'd0);
      ld_ss = 1'b0;
      while (!w_as) begin @(posedge clk); #1; end
      ld_as = 1'b1;
      @(posedge clk); #1;
      check("R10 async clear beats load", {8'd0, c_as}, 12'd0);
      ld_as = 1'b0;

      // R3: mid-cycle load in a clear mode, then counting resumes (R2)
      @(posedge clk); #1;
      ld_ss = 1'b1;
      @(posedge clk); #1;
      check("R3 load preset", {8'd0, c_ss}, 12'd5);
      ld_ss = 1'b0;
      @(posedge clk); #1;
      check("R2 step after load", {8'd0, c_ss}, 12'd6);
      ld_12r = 1'b1;
      @(posedge clk); #1;
      check("R3 wide load preset", c_12r, 12'h800);
      ld_12r = 1'b0;

      // R1: asynchronous reset mid-run
      @(posedge clk); #1;
      rst_n = 1'b0;
      #1;
      check("R1 async reset 12r", c_12r, 12'd0);
      check("R1 async reset 4b", {8'd0, c_a}, 12'd0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R5: carry between slices
      repeat (16) @(posedge clk); #1;
      check("R5 carry at 16", c_12f, 12'd16);
      check("R5 carry reload chain", c_12r, 12'd16);
      repeat (240) @(posedge clk); #1;
      check("R5 carry at 256", c_12f, 12'd256);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule